// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped serial management master for external Ethernet PHYs. It drives the management clock and a bidirectional data line, and it runs both the classic short-address frame (Clause 22) and the extended indirect frame (Clause 45). Software puts the payload in the write-data register and then writes the command register. An accepted command starts one complete frame. The read-data and write-data registers carry the status flags that software polls.

The clock register holds the divider, the frame family and the preamble option, along with the sampling fields, which are stored and read back. In Clause 45 mode an access takes two frames. An address frame carries the 16-bit register number from the write-data register, and a read or write frame to the same device then follows. The data pin is brought out as a separate output, output-enable and input, so the pad cell outside the block forms the tri-state.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The register offsets are command 0x00, write data 0x08, read data 0x10, clock 0x18 and enable 0x20. The command reads back as reg/device[4:0], PHY[12:8] and op[17:16]. The clock register reads back as divider[7:0], sample[11:8], preamble[12], idle[13], sample-mode[15], sample-high[20:16] and family[24]. Reserved bits read 0. After reset the clock register is 0x100A and every other register is 0.
- R2: While enable bit 0 is 0, a command write is ignored. Writing 0 to enable during a frame aborts it: both pending flags clear, MDC goes low and MDIO is released on the next cycle.
- R3: While a frame runs, MDC stays at each level for exactly divider+1 core clocks. MDC is low whenever no frame is pending.
- R4: With preamble bit 12 set, 32 ones are sent before the frame. With it clear, the frame starts at once.
- R5: With family bit 24 = 0, the start code is 01. phy_op 0 sends a write (opcode 01) and phy_op 1 sends a read (opcode 10). The PHY and register fields follow, MSB first. A write then sends turnaround 10 and the 16 write-data bits, MSB first.
- R6: With family bit 24 = 1, the start code is 00 and the opcode equals phy_op: 0 is address, 1 is write, 3 is read and 2 is read-increment. The command's 5-bit address field goes out as the device address, and an address frame carries the 16-bit write-data value.
- R7: During a read, MDIO output-enable is 0 for the two turnaround bits and the 16 data bits. The data is sampled on the MDC rising edges into read-data bits [15:0]. Valid (bit 16) is 1 when the second turnaround bit was sampled 0, and it stays 0 while the read is pending.
- R8: If the second turnaround bit is sampled 1, valid is 0 at the end of the frame, and pending still clears.
- R9: A read sets pending bit 17 of the read-data register. A write or address frame sets pending bit 17 of the write-data register. The flag is visible one cycle after the command write, it clears after the last bit's high phase, and the two flags are never set together.
- R10: A command write made while either flag is pending is ignored. It does not change the command register and does not change the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | ADDR_W | Register byte offset |
| csr_wdata | input | DATA_W | Register write data |
| csr_rdata | output | DATA_W | Register read data for csr_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Serial data output enable |
| mdio_i | input | 1 | Serial data in |

## Verification
A faulty bit counter or shift register shows up in the bit stream captured on MDC rising edges. The bench compares that stream with a frame it builds itself, and the mismatch is caught at the end of the first frame. A faulty divider breaks the MDC half-period measured between edges, within a few core clocks of the first toggle. Faulty pending or valid logic shows in the status registers, either in the cycle after the command write or right after the last bit. This covers refused commands, reads with a bad turnaround and frames aborted by the enable bit.

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int PHASE_W   = 8,
  parameter int PHASE_RST = 10,
  parameter int PRE_LEN   = 32,
  parameter int FRAME_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int TOT    = PRE_LEN + FRAME_LEN;
  localparam int IDX_W  = $clog2(TOT);
  localparam int TA_IDX = TOT - 18;
  localparam logic [ADDR_W-1:0] OFF_CMD  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_WDAT = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFF_RDAT = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFF_CLK  = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] OFF_EN   = ADDR_W'(8'h20);

  logic [4:0] c_reg, c_phy;
  logic [1:0] c_op;
  logic [15:0] wdat, rdat, shin;
  logic rd_val, rd_pend, wr_pend, en;
  logic [PHASE_W-1:0] phase, div;
  logic [3:0] smp;
  logic [4:0] smp_hi;
  logic pre_en, idle_f, smp_mode, c45;
  logic mdc_r, is_rd, ta_ok;
  logic [IDX_W-1:0] idx;
  logic [TOT-1:0] sh;

  wire busy    = rd_pend | wr_pend;
  wire tick    = busy && (div == phase);
  wire cmd_wr  = csr_we && (csr_addr == OFF_CMD);
  wire cmd_acc = cmd_wr && en && !busy;
  wire dis_wr  = csr_we && (csr_addr == OFF_EN) && !csr_wdata[0];

  wire [1:0] n_op = csr_wdata[17:16];
  wire       n_rd = c45 ? n_op[1] : n_op[0];
  wire [1:0] n_st = c45 ? 2'b00 : 2'b01;
  wire [1:0] n_oc = c45 ? n_op : (n_rd ? 2'b10 : 2'b01);
  wire [FRAME_LEN-1:0] frame_n = {n_st, n_oc, csr_wdata[12:8], csr_wdata[4:0], 2'b10, wdat};

  logic unused_bits;
  assign unused_bits = ^{csr_wdata[DATA_W-1:25], csr_wdata[23:21], csr_wdata[14], csr_wdata[7:5]};

  assign mdc     = mdc_r;
  assign mdio_o  = busy & sh[TOT-1];
  assign mdio_oe = busy && !(is_rd && idx >= IDX_W'(TA_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_reg <= '0; c_phy <= '0; c_op <= '0;
      wdat <= '0; rdat <= '0; shin <= '0;
      rd_val <= 1'b0; rd_pend <= 1'b0; wr_pend <= 1'b0; en <= 1'b0;
      phase <= PHASE_W'(PHASE_RST); smp <= '0; smp_hi <= '0;
      pre_en <= 1'b1; idle_f <= 1'b0; smp_mode <= 1'b0; c45 <= 1'b0;
      div <= '0; mdc_r <= 1'b0; is_rd <= 1'b0; ta_ok <= 1'b0;
      idx <= '0; sh <= '0;
    end else begin
      if (tick) begin
        div   <= '0;
        mdc_r <= ~mdc_r;
        if (!mdc_r) begin
          if (is_rd && idx == IDX_W'(TA_IDX + 1)) ta_ok <= !mdio_i;
          if (is_rd && idx >  IDX_W'(TA_IDX + 1)) shin  <= {shin[14:0], mdio_i};
        end else if (idx == IDX_W'(TOT - 1)) begin
          rd_pend <= 1'b0;
          wr_pend <= 1'b0;
          if (is_rd) begin
            rdat   <= shin;
            rd_val <= ta_ok;
          end
        end else begin
          idx <= idx + 1'b1;
          sh  <= sh << 1;
        end
      end else if (busy) begin
        div <= div + 1'b1;
      end

      if (csr_we && csr_addr == OFF_WDAT) wdat <= csr_wdata[15:0];
      if (csr_we && csr_addr == OFF_EN)   en   <= csr_wdata[0];
      if (csr_we && csr_addr == OFF_CLK) begin
        phase    <= csr_wdata[PHASE_W-1:0];
        smp      <= csr_wdata[11:8];
        pre_en   <= csr_wdata[12];
        idle_f   <= csr_wdata[13];
        smp_mode <= csr_wdata[15];
        smp_hi   <= csr_wdata[20:16];
        c45      <= csr_wdata[24];
      end

      if (cmd_acc) begin
        c_reg   <= csr_wdata[4:0];
        c_phy   <= csr_wdata[12:8];
        c_op    <= n_op;
        is_rd   <= n_rd;
        rd_pend <= n_rd;
        wr_pend <= !n_rd;
        ta_ok   <= 1'b0;
        shin    <= '0;
        div     <= '0;
        mdc_r   <= 1'b0;
        idx     <= pre_en ? '0 : IDX_W'(PRE_LEN);
        sh      <= pre_en ? {{PRE_LEN{1'b1}}, frame_n} : {frame_n, {PRE_LEN{1'b0}}};
        if (n_rd) rd_val <= 1'b0;
      end

      if (dis_wr) begin
        if (rd_pend) rd_val <= 1'b0;
        rd_pend <= 1'b0;
        wr_pend <= 1'b0;
        mdc_r   <= 1'b0;
        div     <= '0;
      end
    end
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      OFF_CMD:  csr_rdata[17:0] = {c_op, 3'b000, c_phy, 3'b000, c_reg};
      OFF_WDAT: csr_rdata[17:0] = {wr_pend, 1'b0, wdat};
      OFF_RDAT: csr_rdata[17:0] = {rd_pend, rd_val, rdat};
      OFF_CLK:  csr_rdata[24:0] = {c45, 3'b000, smp_hi, smp_mode, 1'b0, idle_f, pre_en, smp, phase};
      OFF_EN:   csr_rdata[0]    = en;
      default:  csr_rdata = '0;
    endcase
  end

  p_pend_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_pend && wr_pend));
  p_idle_mdc_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !busy);
  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable({c_op, c_phy, c_reg}));
  p_valid_low_inflight_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |-> !rd_val);
endmodule

// File: tb/sim_mdio_mgmt_master.sv
module sim_mdio_mgmt_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic csr_we = 1'b0;
  logic [5:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0, csr_rdata;
  logic mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;

  mdio_mgmt_master u0 (.clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #2 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [63:0] cap, capz;
  int ncap = 0, ivl = 0, ivl_bad = 0, per = 1;
  bit first_edge = 1, mdc_q = 0, rsp_pre = 1, rsp_ta = 0;
  logic [15:0] rsp_d = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic resp(input int k);
    int f = k + (rsp_pre ? 0 : 32);
    if (f == 47) return rsp_ta;
    if (f >= 48 && f <= 63) return rsp_d[63 - f];
    return 1'b1;
  endfunction

  always @(negedge clk) begin
    ivl++;
    if (mdc !== mdc_q) begin
      if (!first_edge && ivl != per) ivl_bad++;
      first_edge = 0;
      ivl = 0;
      if (mdc) begin
        cap  = {cap[62:0], mdio_oe ? mdio_o : 1'b0};
        capz = {capz[62:0], !mdio_oe};
        ncap++;
      end else mdio_i = resp(ncap);
    end
    mdc_q = mdc;
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    csr_addr = a; #1; d = csr_rdata;
  endtask

  function automatic logic [31:0] exp_frame(input bit c45, input logic [1:0] op,
      input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
    bit isrd = c45 ? op[1] : op[0];
    logic [1:0] st = c45 ? 2'b00 : 2'b01;
    logic [1:0] oc = c45 ? op : (isrd ? 2'b10 : 2'b01);
    return {st, oc, phy, rg, isrd ? 18'h0 : {2'b10, wd}};
  endfunction

  task automatic run_op(input bit c45, input bit pre, input logic [7:0] ph, input logic [1:0] op,
      input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd,
      input logic [15:0] rdd, input bit bad_ta, input logic [31:0] junk);
    logic [31:0] v;
    logic [63:0] e;
    bit isrd = c45 ? op[1] : op[0];
    int guard = 0;
    string rq = c45 ? "R6" : "R5";
    wr(6'h18, {7'h0, c45, 11'h0, pre, 4'h0, ph});
    wr(6'h08, {16'h0, wd});
    rsp_pre = pre; rsp_ta = bad_ta; rsp_d = rdd; per = ph + 1;
    cap = '0; capz = '0; ncap = 0; ivl_bad = 0; first_edge = 1; mdio_i = 1'b1;
    wr(6'h00, (junk & 32'hFFFC_E0E0) | {14'h0, op, 3'h0, phy, 3'h0, rg});
    rd(isrd ? 6'h10 : 6'h08, v);
    chk(v[17] == 1'b1, "R9 pending set", v[17], 1);
    if (isrd) chk(v[16] == 1'b0, "R7 valid low in flight", v[16], 0);
    while (v[17] && guard < 3000) begin @(negedge clk); rd(isrd ? 6'h10 : 6'h08, v); guard++; end
    chk(v[17] == 1'b0, "R9 pending cleared", v[17], 0);
    e = pre ? {32'hFFFF_FFFF, exp_frame(c45, op, phy, rg, wd)} : {32'h0, exp_frame(c45, op, phy, rg, wd)};
    chk(cap == e, pre ? "R4 frame bits" : rq, cap, e);
    chk(ncap == (pre ? 64 : 32), "R4 bit count", ncap, pre ? 64 : 32);
    chk(capz == (isrd ? 64'h3FFFF : 64'h0), "R7 release mask", capz, isrd ? 64'h3FFFF : 64'h0);
    chk(ivl_bad == 0, "R3 half period", ivl_bad, 0);
    chk(mdc == 1'b0, "R3 idle low", mdc, 0);
    rd(6'h00, v);
    chk(v == {14'h0, op, 3'h0, phy, 3'h0, rg}, "R1 cmd readback", v, {14'h0, op, 3'h0, phy, 3'h0, rg});
    if (isrd) begin
      rd(6'h10, v);
      if (bad_ta) chk(v[16] == 1'b0, "R8 valid cleared", v[16], 0);
      else begin
        chk(v[16] == 1'b1, "R7 valid", v[16], 1);
        chk(v[15:0] == rdd, "R7 read data", v[15:0], rdd);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(6'h18, v); chk(v == 32'h100A, "R1 clock reset", v, 32'h100A);
    rd(6'h20, v); chk(v == 0, "R1 enable reset", v, 0);
    rd(6'h10, v); chk(v == 0, "R1 read reg reset", v, 0);
    rd(6'h08, v); chk(v == 0, "R1 write reg reset", v, 0);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, v); chk(v == 32'h011F_BFFF, "R1 clock fields", v, 32'h011F_BFFF);
    wr(6'h00, 32'h0001_0305);
    rd(6'h10, v); chk(v[17] == 1'b0, "R2 disabled ignores cmd", v[17], 0);
    rd(6'h00, v); chk(v == 0, "R2 cmd not latched", v, 0);
    wr(6'h20, 32'h1);
    run_op(0, 1, 8'd1, 2'd0, 5'd3, 5'd9, 16'hA5C3, 16'h0, 0, 0);
    run_op(0, 0, 8'd0, 2'd1, 5'd17, 5'd2, 16'h0, 16'h1234, 0, 32'hFFFF_FFFF);
    run_op(1, 1, 8'd2, 2'd0, 5'd5, 5'd1, 16'hBEEF, 16'h0, 0, 0);
    run_op(1, 0, 8'd1, 2'd3, 5'd5, 5'd1, 16'h0, 16'hC0DE, 0, 0);
    run_op(1, 0, 8'd0, 2'd2, 5'd6, 5'd3, 16'h0, 16'h8001, 0, 0);
    run_op(1, 1, 8'd0, 2'd1, 5'd31, 5'd31, 16'h7FFE, 16'h0, 0, 0);
    run_op(0, 1, 8'd3, 2'd1, 5'd0, 5'd0, 16'h0, 16'hFFFF, 1, 0);
    for (int i = 0; i < 14; i++)
      run_op($urandom % 2, $urandom % 2, 8'($urandom % 4), 2'($urandom), 5'($urandom), 5'($urandom),
             16'($urandom), 16'($urandom), ($urandom % 5) == 0, $urandom);
    // R10: second command mid-frame is refused
    wr(6'h18, 32'h0000_1001);
    wr(6'h08, 32'h0000_1111);
    cap = '0; capz = '0; ncap = 0; rsp_pre = 1;
    wr(6'h00, 32'h0000_0204);
    repeat (20) @(negedge clk);
    wr(6'h00, 32'h0001_1F1F);
    rd(6'h00, v); chk(v == 32'h0000_0204, "R10 cmd unchanged", v, 32'h0000_0204);
    rd(6'h10, v); chk(v[17] == 1'b0, "R10 no read started", v[17], 0);
    repeat (600) @(negedge clk);
    rd(6'h08, v); chk(v[17] == 1'b0, "R10 first frame done", v[17], 0);
    chk(cap == {32'hFFFF_FFFF, exp_frame(0, 2'd0, 5'd2, 5'd4, 16'h1111)}, "R10 frame intact",
        cap, {32'hFFFF_FFFF, exp_frame(0, 2'd0, 5'd2, 5'd4, 16'h1111)});
    // R2: abort by clearing enable
    wr(6'h18, 32'h0000_1003);
    wr(6'h00, 32'h0001_0101);
    repeat (300) @(negedge clk);
    wr(6'h20, 32'h0);
    rd(6'h10, v); chk(v[17:16] == 2'b00, "R2 abort clears pending", v[17:16], 0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R2 abort releases line", {mdc, mdio_oe}, 0);
    ncap = 0;
    wr(6'h00, 32'h0000_0101);
    repeat (60) @(negedge clk);
    chk(ncap == 0, "R2 no clock while disabled", ncap, 0);
    rd(6'h08, v); chk(v[17] == 1'b0, "R2 no pending while disabled", v[17], 0);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule